// File: doc/BRIEF.md
# BCD Time-of-Day Counter with Field-Masked Alarm

This block keeps wall-clock time from a one-second tick pulse. Seconds, minutes and hours are held as packed BCD bytes, so software can read and write them as printable digit pairs. Elapsed days are held as a 15-bit binary count that is reached through two byte addresses. Counting runs only while a run bit in the control byte is set.

An alarm compares the minute, hour and day against three alarm registers at the instant the seconds roll over to 00. Each of the three fields has its own enable. When every enabled field matches, a sticky flag is raised, and this flag can drive an interrupt output.

All state is reached through an 8-bit address/write-data port. Writes take effect on the clock edge, and read data follows the address combinationally. A busy bit marks the cycle in which a tick update lands. Time-register writes that arrive in that cycle are dropped, so software polls busy before it loads the time.

Top module: `bcd_clock_alarm`

## Requirements
- R1: After reset every register reads 0x00 and `alarm_irq` is low.
- R2: Each counted tick advances seconds (address 0x15) in BCD from 0x00 to 0x59. Seconds then wrap to 0x00 and carry one into minutes (address 0x16), which also count 0x00..0x59 in BCD. A low digit of 9 rolls to 0 and increments the high digit.
- R3: Hours (address 0x17) count 0x00..0x23 in BCD. They advance when minutes wrap, and the hour wrap from 0x23 to 0x00 carries into the day count.
- R4: The day count is 15-bit binary. Its low byte is at 0x18 and bits 14:8 are at 0x19, read with bit 7 as zero. It wraps from 32767 to 0.
- R5: Ticks are ignored unless control bit 0 (run) is set. The time then holds.
- R6: Control byte at 0x14 uses these bits: 7 busy (read-only), 5 day-match enable, 4 hour-match enable, 3 minute-match enable, 2 alarm flag, 1 interrupt enable, 0 run. Busy reads 1 exactly in a cycle where a tick arrives while run is set.
- R7: A write to addresses 0x15..0x19 in a busy cycle is discarded, and the tick's update stands. The same write outside a busy cycle loads the register.
- R8: Alarm minute (0x1A), alarm hour (0x1B) and alarm day low/high (0x1C/0x1D) read back as written. The flag sets on the edge at which seconds roll to 00, when at least one match enable is set and every enabled field equals the newly reached minute, hour and day.
- R9: A field whose match enable is clear takes no part in the comparison. A mismatch in that field does not stop the alarm.
- R10: The flag is sticky. Writing 1 to control bit 2 clears it, and writing 0 leaves it unchanged. A set and a clear on the same edge leave it set.
- R11: `alarm_irq` is high exactly while the flag and control bit 1 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
The BCD-range properties assume that software only loads valid BCD digit pairs within each field's range. The bench keeps to this by writing only legal values such as 0x59 and 0x23. The properties also assume that `sec_tick` is a single-cycle pulse, and the bench spaces its pulses at least one idle cycle apart. Writes that collide with a tick are driven only where the discard and set-over-clear rules are under test.

// File: rtl/rtc_cal_pkg.sv
// rtc_cal_pkg: register map, control bit positions and shared types for the
// BCD time-of-day counter. Assumes an 8-bit register port.
package rtc_cal_pkg;

    localparam int BUS_W = 8;
    localparam int ADAY_W = 2 * BUS_W;

    localparam logic [7:0] ADR_CTRL    = 8'h14;
    localparam logic [7:0] ADR_SEC     = 8'h15;
    localparam logic [7:0] ADR_MIN     = 8'h16;
    localparam logic [7:0] ADR_HOUR    = 8'h17;
    localparam logic [7:0] ADR_DAY_LO  = 8'h18;
    localparam logic [7:0] ADR_DAY_HI  = 8'h19;
    localparam logic [7:0] ADR_AMIN    = 8'h1A;
    localparam logic [7:0] ADR_AHOUR   = 8'h1B;
    localparam logic [7:0] ADR_ADAY_LO = 8'h1C;
    localparam logic [7:0] ADR_ADAY_HI = 8'h1D;

    localparam int CB_DAY_EN  = 5;
    localparam int CB_HOUR_EN = 4;
    localparam int CB_MIN_EN  = 3;
    localparam int CB_FLAG    = 2;
    localparam int CB_IRQ_EN  = 1;
    localparam int CB_RUN     = 0;

    typedef struct packed {
        logic day_en;
        logic hour_en;
        logic min_en;
        logic irq_en;
        logic run;
    } cal_ctrl_t;

    typedef struct packed {
        logic sec;
        logic min;
        logic hour;
        logic day_lo;
        logic day_hi;
        logic amin;
        logic ahour;
        logic aday_lo;
        logic aday_hi;
    } cal_wsel_t;

    // Next value of a packed-BCD field that wraps to zero after 'top'.
    function automatic logic [7:0] bcd_next(input logic [7:0] v, input logic [7:0] top);
        if (v == top) begin
            return 8'h00;
        end
        if (v[3:0] == 4'd9) begin
            return {v[7:4] + 4'd1, 4'd0};
        end
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

endpackage

// File: rtl/cal_bcd_field.sv
// cal_bcd_field: one packed-BCD time field (seconds, minutes or hours).
// Advances on 'step', wraps after TOP and reports the wrap as a carry.
// Assumes loads carry valid BCD no larger than TOP and never coincide
// with a step (the register port gates them with busy).
module cal_bcd_field
    import rtc_cal_pkg::*;
#(
    parameter logic [7:0] TOP = 8'h59
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    input  logic       ld,
    input  logic [7:0] ld_val,
    output logic [7:0] val,
    output logic [7:0] nxt,
    output logic       wrap
);

    // Carry out and look-ahead value for the alarm comparison.
    always_comb begin
        wrap = step && (val == TOP);
        nxt  = step ? bcd_next(val, TOP) : val;
    end

    // Field register: reset, count or load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val <= 8'h00;
        end else if (step) begin
            val <= nxt;
        end else if (ld) begin
            val <= ld_val;
        end
    end

    a_r2_bcd_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (val[3:0] <= 4'd9) && (val <= TOP));

    a_r2_step_moves: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (val != $past(val)));

    a_r7_load_not_with_step: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !ld);

    a_r5_field_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !ld) |=> $stable(val));

endmodule

// File: rtl/cal_day_count.sv
// cal_day_count: binary day counter of DAY_W bits loaded one byte at a time.
// Wraps from all-ones to zero. Assumes 8 < DAY_W <= 16 and no load while stepping.
module cal_day_count
    import rtc_cal_pkg::*;
#(
    parameter int DAY_W = 15,
    localparam int HI_W = DAY_W - BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             ld_lo,
    input  logic             ld_hi,
    input  logic [BUS_W-1:0] lo_val,
    input  logic [HI_W-1:0]  hi_val,
    output logic [DAY_W-1:0] cnt,
    output logic [DAY_W-1:0] nxt
);

    // Look-ahead day value.
    always_comb begin
        nxt = step ? cnt + 1'b1 : cnt;
    end

    // Day register: reset, count, or byte loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= nxt;
        end else begin
            if (ld_lo) begin
                cnt[BUS_W-1:0] <= lo_val;
            end
            if (ld_hi) begin
                cnt[DAY_W-1:BUS_W] <= hi_val;
            end
        end
    end

    a_r4_day_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step && (cnt == {DAY_W{1'b1}})) |=> (cnt == '0));

    a_r5_day_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !ld_lo && !ld_hi) |=> $stable(cnt));

endmodule

// File: rtl/cal_alarm_unit.sv
// cal_alarm_unit: alarm minute/hour/day registers, field-masked comparison
// taken at the seconds rollover, and the sticky alarm flag.
// Assumes 'now_*' are the values the counter reaches on this edge.
module cal_alarm_unit
    import rtc_cal_pkg::*;
#(
    parameter int DAY_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_min,
    input  logic              wr_hour,
    input  logic              wr_day_lo,
    input  logic              wr_day_hi,
    input  logic [BUS_W-1:0]  wdata,
    input  logic              min_en,
    input  logic              hour_en,
    input  logic              day_en,
    input  logic              roll,
    input  logic [7:0]        now_min,
    input  logic [7:0]        now_hour,
    input  logic [DAY_W-1:0]  now_day,
    input  logic              clr,
    output logic [7:0]        a_min,
    output logic [7:0]        a_hour,
    output logic [ADAY_W-1:0] a_day,
    output logic              flag
);

    logic any_en;
    logic hit;

    // Match: rollover, at least one enabled field, all enabled fields equal.
    always_comb begin
        any_en = min_en || hour_en || day_en;
        hit    = roll && any_en
              && (!min_en  || (now_min  == a_min))
              && (!hour_en || (now_hour == a_hour))
              && (!day_en  || (ADAY_W'(now_day) == a_day));
    end

    // Alarm setting registers, always writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_min  <= 8'h00;
            a_hour <= 8'h00;
            a_day  <= '0;
        end else begin
            if (wr_min) begin
                a_min <= wdata;
            end
            if (wr_hour) begin
                a_hour <= wdata;
            end
            if (wr_day_lo) begin
                a_day[BUS_W-1:0] <= wdata;
            end
            if (wr_day_hi) begin
                a_day[ADAY_W-1:BUS_W] <= wdata;
            end
        end
    end

    // Sticky flag: a match wins over a clear on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (hit) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    a_r8_rise_on_roll: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(roll));

    a_r9_rise_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(min_en || hour_en || day_en));

endmodule

// File: rtl/cal_reg_port.sv
// cal_reg_port: address decode, control register, busy status and read mux.
// Time-register write strobes are suppressed in a busy cycle.
module cal_reg_port
    import rtc_cal_pkg::*;
#(
    parameter int DAY_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [5:0]        ctl_wdata,
    input  logic [7:0]        sec,
    input  logic [7:0]        min,
    input  logic [7:0]        hour,
    input  logic [DAY_W-1:0]  day,
    input  logic [7:0]        a_min,
    input  logic [7:0]        a_hour,
    input  logic [ADAY_W-1:0] a_day,
    input  logic              flag,
    output cal_ctrl_t         ctrl,
    output cal_wsel_t         wsel,
    output logic              busy,
    output logic              flag_clr,
    output logic [BUS_W-1:0]  bus_rdata
);

    logic ctrl_wr;

    // Busy marks the cycle whose edge carries a tick update.
    always_comb begin
        busy = sec_tick && ctrl.run;
    end

    // Write decode; time fields are blocked while busy.
    always_comb begin
        ctrl_wr      = bus_wr && (bus_addr == ADR_CTRL);
        flag_clr     = ctrl_wr && ctl_wdata[CB_FLAG];
        wsel.sec     = bus_wr && !busy && (bus_addr == ADR_SEC);
        wsel.min     = bus_wr && !busy && (bus_addr == ADR_MIN);
        wsel.hour    = bus_wr && !busy && (bus_addr == ADR_HOUR);
        wsel.day_lo  = bus_wr && !busy && (bus_addr == ADR_DAY_LO);
        wsel.day_hi  = bus_wr && !busy && (bus_addr == ADR_DAY_HI);
        wsel.amin    = bus_wr && (bus_addr == ADR_AMIN);
        wsel.ahour   = bus_wr && (bus_addr == ADR_AHOUR);
        wsel.aday_lo = bus_wr && (bus_addr == ADR_ADAY_LO);
        wsel.aday_hi = bus_wr && (bus_addr == ADR_ADAY_HI);
    end

    // Control register holding the enables and the run bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (ctrl_wr) begin
            ctrl.day_en  <= ctl_wdata[CB_DAY_EN];
            ctrl.hour_en <= ctl_wdata[CB_HOUR_EN];
            ctrl.min_en  <= ctl_wdata[CB_MIN_EN];
            ctrl.irq_en  <= ctl_wdata[CB_IRQ_EN];
            ctrl.run     <= ctl_wdata[CB_RUN];
        end
    end

    // Read-back multiplexer.
    always_comb begin
        case (bus_addr)
            ADR_CTRL:    bus_rdata = {busy, 1'b0, ctrl.day_en, ctrl.hour_en,
                                      ctrl.min_en, flag, ctrl.irq_en, ctrl.run};
            ADR_SEC:     bus_rdata = sec;
            ADR_MIN:     bus_rdata = min;
            ADR_HOUR:    bus_rdata = hour;
            ADR_DAY_LO:  bus_rdata = day[BUS_W-1:0];
            ADR_DAY_HI:  bus_rdata = BUS_W'(day[DAY_W-1:BUS_W]);
            ADR_AMIN:    bus_rdata = a_min;
            ADR_AHOUR:   bus_rdata = a_hour;
            ADR_ADAY_LO: bus_rdata = a_day[BUS_W-1:0];
            ADR_ADAY_HI: bus_rdata = a_day[ADAY_W-1:BUS_W];
            default:     bus_rdata = '0;
        endcase
    end

    a_r6_run_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_wr) |=> $stable(ctrl));

endmodule

// File: rtl/bcd_clock_alarm.sv
// bcd_clock_alarm: top of the BCD time-of-day counter with field-masked alarm.
// Chains seconds -> minutes -> hours -> days through wrap carries, feeds the
// look-ahead values to the alarm comparator and gates the interrupt.
// Assumes sec_tick is a one-cycle pulse synchronous to clk.
module bcd_clock_alarm
    import rtc_cal_pkg::*;
#(
    parameter int DAY_W = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic       bus_wr,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       alarm_irq
);

    localparam int HI_W = DAY_W - BUS_W;

    cal_ctrl_t         ctrl;
    cal_wsel_t         wsel;
    logic              busy;
    logic              flag_clr;
    logic              flag;
    logic [7:0]        sec, min, hour;
    logic [7:0]        sec_nxt, min_nxt, hour_nxt;
    logic              sec_wrap, min_wrap, hour_wrap;
    logic [DAY_W-1:0]  day, day_nxt;
    logic [7:0]        a_min, a_hour;
    logic [ADAY_W-1:0] a_day;

    cal_reg_port #(.DAY_W(DAY_W)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_tick  (sec_tick),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .ctl_wdata (bus_wdata[5:0]),
        .sec       (sec),
        .min       (min),
        .hour      (hour),
        .day       (day),
        .a_min     (a_min),
        .a_hour    (a_hour),
        .a_day     (a_day),
        .flag      (flag),
        .ctrl      (ctrl),
        .wsel      (wsel),
        .busy      (busy),
        .flag_clr  (flag_clr),
        .bus_rdata (bus_rdata)
    );

    cal_bcd_field #(.TOP(8'h59)) u_sec (
        .clk (clk), .rst_n (rst_n), .step (busy), .ld (wsel.sec),
        .ld_val (bus_wdata), .val (sec), .nxt (sec_nxt), .wrap (sec_wrap)
    );

    cal_bcd_field #(.TOP(8'h59)) u_min (
        .clk (clk), .rst_n (rst_n), .step (sec_wrap), .ld (wsel.min),
        .ld_val (bus_wdata), .val (min), .nxt (min_nxt), .wrap (min_wrap)
    );

    cal_bcd_field #(.TOP(8'h23)) u_hour (
        .clk (clk), .rst_n (rst_n), .step (min_wrap), .ld (wsel.hour),
        .ld_val (bus_wdata), .val (hour), .nxt (hour_nxt), .wrap (hour_wrap)
    );

    cal_day_count #(.DAY_W(DAY_W)) u_day (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (hour_wrap),
        .ld_lo  (wsel.day_lo),
        .ld_hi  (wsel.day_hi),
        .lo_val (bus_wdata),
        .hi_val (bus_wdata[HI_W-1:0]),
        .cnt    (day),
        .nxt    (day_nxt)
    );

    cal_alarm_unit #(.DAY_W(DAY_W)) u_alarm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_min    (wsel.amin),
        .wr_hour   (wsel.ahour),
        .wr_day_lo (wsel.aday_lo),
        .wr_day_hi (wsel.aday_hi),
        .wdata     (bus_wdata),
        .min_en    (ctrl.min_en),
        .hour_en   (ctrl.hour_en),
        .day_en    (ctrl.day_en),
        .roll      (sec_wrap),
        .now_min   (min_nxt),
        .now_hour  (hour_nxt),
        .now_day   (day_nxt),
        .clr       (flag_clr),
        .a_min     (a_min),
        .a_hour    (a_hour),
        .a_day     (a_day),
        .flag      (flag)
    );

    // Interrupt request: flag gated by its enable.
    always_comb begin
        alarm_irq = flag && ctrl.irq_en;
    end

    a_r5_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.run && !bus_wr) |=> $stable({sec, min, hour, day}));

    a_r3_hour_carry_day: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (sec == 8'h59) && (min == 8'h59) && (hour == 8'h23)) |=> (hour == 8'h00));

endmodule

// File: tb/bcd_clock_alarm_tb_top.sv
// Bench for bcd_clock_alarm: table-driven counting vectors, then directed
// tests for reset, run gating, busy, write discard and the alarm.
module bcd_clock_alarm_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       alarm_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    bcd_clock_alarm dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_tick  (sec_tick),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .alarm_irq (alarm_irq)
    );

    typedef struct packed {
        logic [7:0]  s;
        logic [7:0]  m;
        logic [7:0]  h;
        logic [15:0] d;
        logic [7:0]  n;
        logic [7:0]  es;
        logic [7:0]  em;
        logic [7:0]  eh;
        logic [15:0] ed;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{8'h00, 8'h00, 8'h00, 16'h0000, 8'd1,  8'h01, 8'h00, 8'h00, 16'h0000},
        '{8'h09, 8'h00, 8'h00, 16'h0000, 8'd1,  8'h10, 8'h00, 8'h00, 16'h0000},
        '{8'h59, 8'h00, 8'h00, 16'h0000, 8'd1,  8'h00, 8'h01, 8'h00, 16'h0000},
        '{8'h59, 8'h09, 8'h00, 16'h0000, 8'd1,  8'h00, 8'h10, 8'h00, 16'h0000},
        '{8'h59, 8'h59, 8'h00, 16'h0000, 8'd1,  8'h00, 8'h00, 8'h01, 16'h0000},
        '{8'h59, 8'h59, 8'h09, 16'h0000, 8'd1,  8'h00, 8'h00, 8'h10, 16'h0000},
        '{8'h59, 8'h59, 8'h23, 16'h0005, 8'd1,  8'h00, 8'h00, 8'h00, 16'h0006},
        '{8'h59, 8'h59, 8'h23, 16'h00FF, 8'd1,  8'h00, 8'h00, 8'h00, 16'h0100},
        '{8'h59, 8'h59, 8'h23, 16'h7FFF, 8'd1,  8'h00, 8'h00, 8'h00, 16'h0000},
        '{8'h50, 8'h00, 8'h00, 16'h0000, 8'd15, 8'h05, 8'h01, 8'h00, 16'h0000}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic tick_pulse();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] s, input logic [7:0] m,
                            input logic [7:0] h, input logic [15:0] d);
        reg_write(8'h14, 8'h00);
        reg_write(8'h15, s);
        reg_write(8'h16, m);
        reg_write(8'h17, h);
        reg_write(8'h18, d[7:0]);
        reg_write(8'h19, d[15:8]);
    endtask

    task automatic set_alarm(input logic [7:0] m, input logic [7:0] h, input logic [15:0] d);
        reg_write(8'h1A, m);
        reg_write(8'h1B, h);
        reg_write(8'h1C, d[7:0]);
        reg_write(8'h1D, d[15:8]);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic [7:0] rd2;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every register and the interrupt
        for (int a = 8'h14; a <= 8'h1D; a++) begin
            reg_read(8'(a), rd);
            check("R1 reset register", {8'h00, rd}, 16'h0000);
        end
        check("R1 reset irq", {15'h0, alarm_irq}, 16'h0000);

        // R2 R3 R4: table of counting vectors
        for (int i = 0; i < NVEC; i++) begin
            set_time(VECS[i].s, VECS[i].m, VECS[i].h, VECS[i].d);
            reg_write(8'h14, 8'h01);
            for (int k = 0; k < int'(VECS[i].n); k++) begin
                tick_pulse();
            end
            reg_read(8'h15, rd);
            check("R2 seconds", {8'h00, rd}, {8'h00, VECS[i].es});
            reg_read(8'h16, rd);
            check("R2 minutes", {8'h00, rd}, {8'h00, VECS[i].em});
            reg_read(8'h17, rd);
            check("R3 hours", {8'h00, rd}, {8'h00, VECS[i].eh});
            reg_read(8'h18, rd);
            reg_read(8'h19, rd2);
            check("R4 day count", {rd2, rd}, VECS[i].ed);
        end

        // R5: tick ignored while run is clear
        set_time(8'h30, 8'h00, 8'h00, 16'h0000);
        tick_pulse();
        reg_read(8'h15, rd);
        check("R5 stopped seconds", {8'h00, rd}, 16'h0030);

        // R6: busy visible only in the tick cycle while running
        reg_write(8'h14, 8'h01);
        @(negedge clk);
        sec_tick = 1'b1;
        bus_addr = 8'h14;
        #1;
        check("R6 busy in tick cycle", {8'h00, bus_rdata}, 16'h0081);
        @(negedge clk);
        sec_tick = 1'b0;
        reg_read(8'h14, rd);
        check("R6 busy clear", {8'h00, rd}, 16'h0001);
        reg_read(8'h15, rd);
        check("R6 tick counted", {8'h00, rd}, 16'h0031);

        // R7: a time write colliding with a tick is discarded
        @(negedge clk);
        sec_tick = 1'b1;
        bus_wr = 1'b1;
        bus_addr = 8'h15;
        bus_wdata = 8'h44;
        @(negedge clk);
        sec_tick = 1'b0;
        bus_wr = 1'b0;
        reg_read(8'h15, rd);
        check("R7 write discarded", {8'h00, rd}, 16'h0032);
        reg_write(8'h15, 8'h44);
        reg_read(8'h15, rd);
        check("R7 write outside busy", {8'h00, rd}, 16'h0044);

        // R8: alarm registers read back
        set_alarm(8'h05, 8'h12, 16'h1234);
        reg_read(8'h1A, rd);
        check("R8 alarm minute", {8'h00, rd}, 16'h0005);
        reg_read(8'h1B, rd);
        check("R8 alarm hour", {8'h00, rd}, 16'h0012);
        reg_read(8'h1C, rd);
        reg_read(8'h1D, rd2);
        check("R8 alarm day", {rd2, rd}, 16'h1234);

        // R8 R11: full match fires at the rollover to 12:05:00
        set_time(8'h59, 8'h04, 8'h12, 16'h1234);
        reg_write(8'h14, 8'h3B);
        reg_read(8'h14, rd);
        check("R8 no flag before roll", {8'h00, rd}, 16'h003B);
        tick_pulse();
        reg_read(8'h14, rd);
        check("R8 flag on match", {8'h00, rd}, 16'h003F);
        check("R11 irq with enable", {15'h0, alarm_irq}, 16'h0001);

        // R10: sticky, write 0 keeps, write 1 clears
        tick_pulse();
        reg_read(8'h14, rd);
        check("R10 flag sticky", {8'h00, rd}, 16'h003F);
        reg_write(8'h14, 8'h3B);
        reg_read(8'h14, rd);
        check("R10 write zero keeps", {8'h00, rd}, 16'h003F);
        reg_write(8'h14, 8'h3F);
        reg_read(8'h14, rd);
        check("R10 write one clears", {8'h00, rd}, 16'h003B);
        check("R11 irq drops", {15'h0, alarm_irq}, 16'h0000);

        // R9 R11: hour-only match ignores minute mismatch; irq gated off
        set_time(8'h59, 8'h40, 8'h12, 16'h0001);
        reg_write(8'h14, 8'h11);
        tick_pulse();
        reg_read(8'h14, rd);
        check("R9 hour-only fires", {8'h00, rd}, 16'h0015);
        check("R11 irq masked", {15'h0, alarm_irq}, 16'h0000);
        reg_write(8'h14, 8'h13);
        #1;
        check("R11 irq after enable", {15'h0, alarm_irq}, 16'h0001);
        reg_write(8'h14, 8'h17);
        reg_read(8'h14, rd);
        check("R10 clear again", {8'h00, rd}, 16'h0013);

        // R9: enabled minute mismatch blocks the alarm
        set_time(8'h59, 8'h41, 8'h12, 16'h0001);
        reg_write(8'h14, 8'h09);
        tick_pulse();
        reg_read(8'h14, rd);
        check("R9 minute mismatch", {8'h00, rd}, 16'h0009);

        // R8: no field enabled, no alarm even though all fields match
        set_time(8'h59, 8'h04, 8'h12, 16'h1234);
        reg_write(8'h14, 8'h01);
        tick_pulse();
        reg_read(8'h14, rd);
        check("R8 no enable no flag", {8'h00, rd}, 16'h0001);

        // R10: set and clear on one edge leave the flag set
        set_time(8'h59, 8'h04, 8'h12, 16'h1234);
        reg_write(8'h14, 8'h3B);
        @(negedge clk);
        sec_tick = 1'b1;
        bus_wr = 1'b1;
        bus_addr = 8'h14;
        bus_wdata = 8'h3F;
        @(negedge clk);
        sec_tick = 1'b0;
        bus_wr = 1'b0;
        reg_read(8'h14, rd);
        check("R10 set wins", {8'h00, rd}, 16'h003F);

        // R1: reset in mid-run returns to the cleared state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        reg_read(8'h14, rd);
        check("R1 ctrl after reset", {8'h00, rd}, 16'h0000);
        reg_read(8'h17, rd);
        check("R1 hour after reset", {8'h00, rd}, 16'h0000);
        check("R1 irq after reset", {15'h0, alarm_irq}, 16'h0000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule